// File: doc/BRIEF.md
# Translated-Access Permission Checker

This block decides whether a memory access that has already been translated may go ahead. It takes the attributes of the translation entry that matched, the kind of access and the current control state. It returns one verdict: grant, or a single fault. A fault carries a kind, a choice between an instruction-side (prefetch) abort and a data-side abort, a flag that marks it as a second-stage fault, and the lookup level of the entry.

Several independent checks run in parallel. These are the second-stage table-walk check, the alignment check, the uncacheable-prefetch check, the domain decode, and the access-permission and execute-never checks. A fixed priority picks the first fault among them. The verdict is registered: it appears one cycle after an input strobe, together with a one-cycle valid pulse.

The number of domains, the address slice width used for alignment and the level width are parameters.

Top module: `xlat_perm_check`

## Requirements
- R1: The outputs are registered. `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. The other outputs load only on a strobe and hold otherwise. Reset clears every output to zero. Fault codes: 0 none, 1 alignment, 2 domain, 3 permission, 4 uncacheable prefetch. Access codes on `in_acc`: 0 read, 1 write, 2 fetch, 3 read.
- R2: A cache-maintenance request (`in_cmaint`) is granted with fault 0, no abort flags and level 0, whatever the other inputs are.
- R3: A second-stage check (`in_stage2`) on a request that is itself a table walk (`in_walk`) faults when `ctl_walk_chk` is set and the entry is not Normal memory. The result is fault 3, data abort, second-stage flag 1, and level = `ent_level`.
- R4: A non-fetch access whose `in_addr & in_size_mask` is nonzero raises fault 1 when the entry is not Normal memory or `ctl_align` is set. The result is a data abort, second-stage flag = `in_stage2`, and level 0. A zero masked value never raises it.
- R5: A prefetch request (`in_prefetch`) to a non-cacheable entry raises fault 4 with the prefetch-abort flag set, second-stage flag = `in_stage2`, and level 0.
- R6: For short-format entries, a 2-bit control is read from `ctl_dacr` at bit 2×`ent_dom`. Values 0 and 2 give fault 2, with a prefetch abort for a fetch and a data abort otherwise, second-stage flag = `in_stage2`, and level = `ent_level`. Value 3 grants with no permission check. Value 1 goes on to the permission check. Long-format entries skip this decode.
- R7: The effective 3-bit AP is `ent_ap` for short format and `{ent_ap[1:0],0}` for long format. Bit 0 is then forced to 1 when the entry is long format or `ctl_afe` is set.
- R8: First-stage AP decode:
  - AP 0 and AP 4 always fail.
  - AP 1 fails when unprivileged; writable when privileged.
  - AP 2 fails on an unprivileged write; writable when privileged.
  - AP 3 never fails; always writable.
  - AP 5 fails when unprivileged or on a write.
  - AP 6 and AP 7 fail on a write.
  - An entry is writable only under AP 1, AP 2 and AP 3. In a second-stage check, the AP decode never fails and the entry counts as writable.
- R9: In a second-stage check, the HAP test fails a write when `ent_hap[1]` is 0 and fails a read when `ent_hap[0]` is 0.
- R10: Execute-never is set by any of three terms: `ent_xn`; writable together with `ctl_wxn`; or effective AP 3 together with `ctl_uwxn` and a privileged access.
- R11: A fetch fails with fault 3, prefetch abort, second-stage flag = `in_stage2` and level = `ent_level` when any of these holds:
  - the AP decode failed;
  - execute-never is set;
  - `ent_pxn` is set on a long-format entry with a privileged access;
  - the access is secure while `ent_ns` and `ctl_sif` are both set.
- R12: A non-fetch access fails with fault 3, data abort and level = `ent_level` when the AP decode or the HAP test fails. The second-stage flag is `in_stage2` OR (AP decode passed).
- R13: When several checks fire, the first one in this order is reported: cache-maintenance bypass, walk check, alignment, uncacheable prefetch, domain, permissions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input strobe |
| in_acc | input | 2 | Access kind |
| in_priv | input | 1 | Privileged access |
| in_secure | input | 1 | Access made in secure state |
| in_prefetch | input | 1 | Request is a prefetch |
| in_cmaint | input | 1 | Request is cache maintenance |
| in_walk | input | 1 | Request is a first-stage table walk |
| in_stage2 | input | 1 | Check runs as second stage |
| in_addr | input | AW | Low address bits |
| in_size_mask | input | AW | Access-size alignment mask |
| ent_ap | input | 3 | Entry access permissions |
| ent_hap | input | 2 | Entry second-stage permissions |
| ent_xn | input | 1 | Entry execute-never |
| ent_pxn | input | 1 | Entry privileged execute-never |
| ent_dom | input | DOM_W | Entry domain number |
| ent_normal | input | 1 | Entry is Normal memory |
| ent_nc | input | 1 | Entry is non-cacheable |
| ent_ns | input | 1 | Entry is non-secure |
| ent_long | input | 1 | Entry uses long format |
| ent_level | input | LVL_W | Entry lookup level |
| ctl_dacr | input | 2*NDOM | Domain access controls |
| ctl_align | input | 1 | Alignment checking for all memory |
| ctl_afe | input | 1 | Simplified access-permission mode |
| ctl_wxn | input | 1 | Writable implies execute-never |
| ctl_uwxn | input | 1 | Fully accessible implies privileged execute-never |
| ctl_sif | input | 1 | Secure fetch from non-secure memory blocked |
| ctl_walk_chk | input | 1 | Walks to device memory fault |
| out_valid | output | 1 | Verdict valid pulse |
| out_grant | output | 1 | Access granted |
| out_fault | output | 3 | Fault kind |
| out_pabt | output | 1 | Prefetch abort (else data abort) |
| out_s2 | output | 1 | Fault reported as second stage |
| out_level | output | LVL_W | Lookup level of the fault |

## Verification
The main sweep walks every effective AP value over every access kind, privilege, format, simplified-AP mode, WXN/UWXN setting, stage and HAP value. This separates the AP table, the writability that feeds execute-never, and the stage-dependent abort flag. A domain sweep sets each domain's 2-bit control to all four values for each access kind, with both a no-access and a full-access AP. This shows that domain faults fire and that the manager value skips the permission check. A pseudo-random run then sets many checks at once to exercise the priority order, and directed vectors pin alignment masks, the cache-maintenance bypass and output holding.

// File: rtl/apc_pkg.sv
package apc_pkg;

   typedef enum logic [1:0] {
      ACC_READ     = 2'd0,
      ACC_WRITE    = 2'd1,
      ACC_FETCH    = 2'd2,
      ACC_READ_ALT = 2'd3
   } acc_e;

   typedef enum logic [2:0] {
      FLT_NONE   = 3'd0,
      FLT_ALIGN  = 3'd1,
      FLT_DOMAIN = 3'd2,
      FLT_PERM   = 3'd3,
      FLT_UNCPF  = 3'd4
   } fault_e;

   typedef struct packed {
      logic   grant;
      fault_e fault;
      logic   pabt;
      logic   s2;
      logic   use_level;
   } verdict_t;

endpackage

// File: rtl/apc_dom_sel.sv
module apc_dom_sel #(
   parameter int NDOM  = 16,
   parameter int DOM_W = 4
) (
   input  logic [2*NDOM-1:0] dacr,
   input  logic [DOM_W-1:0]  dom,
   input  logic              long_fmt,
   output logic              dom_fault,
   output logic              dom_mgr
);

   logic [1:0] fld;

   generate
      if ((NDOM & (NDOM - 1)) != 0) begin : g_bad_ndom
         $error("apc_dom_sel: NDOM must be a power of two");
      end
      if (NDOM == 1) begin : g_single
         assign fld = dacr[1:0];
      end else begin : g_multi
         logic [1:0] fields [NDOM];
         for (genvar i = 0; i < NDOM; i++) begin : g_fld
            assign fields[i] = dacr[2*i +: 2];
         end
         assign fld = fields[dom];
      end
   endgenerate

   // R6: 0 and 2 fault, 3 is manager, 1 is client
   assign dom_fault = !long_fmt && !fld[0];
   assign dom_mgr   = !long_fmt && (fld == 2'b11);

endmodule

// File: rtl/apc_ap_eval.sv
module apc_ap_eval
   import apc_pkg::*;
(
   input  acc_e       acc,
   input  logic       priv,
   input  logic       secure,
   input  logic       stage2,
   input  logic [2:0] ap,
   input  logic [1:0] hap,
   input  logic       xn,
   input  logic       pxn,
   input  logic       long_fmt,
   input  logic       ns,
   input  logic       afe,
   input  logic       wxn,
   input  logic       uwxn,
   input  logic       sif,
   output logic       ap_abt,
   output logic       hap_abt,
   output logic       fetch_abt
);

   logic [2:0] apx;
   logic       is_wr;
   logic       writable;
   logic       s1_abt;
   logic       s1_wr;
   logic       xn_eff;

   assign is_wr = (acc == ACC_WRITE);

   // R7: effective AP
   always_comb begin
      apx = long_fmt ? {ap[1:0], 1'b0} : ap;
      if (long_fmt || afe) apx[0] = 1'b1;
   end

   // R8: first-stage AP decode
   always_comb begin
      s1_abt = 1'b1;
      s1_wr  = 1'b0;
      unique case (apx)
         3'd1: begin s1_abt = !priv;           s1_wr = priv; end
         3'd2: begin s1_abt = !priv && is_wr;  s1_wr = priv; end
         3'd3: begin s1_abt = 1'b0;            s1_wr = 1'b1; end
         3'd5: begin s1_abt = !priv || is_wr;  s1_wr = 1'b0; end
         3'd6,
         3'd7: begin s1_abt = is_wr;           s1_wr = 1'b0; end
         default: begin s1_abt = 1'b1;         s1_wr = 1'b0; end
      endcase
   end

   assign ap_abt   = stage2 ? 1'b0 : s1_abt;
   assign writable = stage2 ? 1'b1 : s1_wr;

   // R9: second-stage permissions
   assign hap_abt = stage2 && (is_wr ? !hap[1] : !hap[0]);

   // R10: execute-never
   assign xn_eff = xn || (writable && wxn) || ((apx == 3'd3) && uwxn && priv);

   // R11: fetch abort terms
   assign fetch_abt = ap_abt || xn_eff || (long_fmt && pxn && priv) ||
                      (secure && ns && sif);

endmodule

// File: rtl/apc_arbiter.sv
module apc_arbiter
   import apc_pkg::*;
(
   input  logic     cmaint,
   input  logic     walk_hit,
   input  logic     align_hit,
   input  logic     uncpf_hit,
   input  logic     dom_fault,
   input  logic     dom_mgr,
   input  logic     is_fetch,
   input  logic     fetch_abt,
   input  logic     ap_abt,
   input  logic     hap_abt,
   input  logic     stage2,
   output verdict_t verdict
);

   // R13: fixed priority, first hit wins
   always_comb begin
      verdict = '{grant: 1'b0, fault: FLT_NONE, pabt: 1'b0, s2: 1'b0, use_level: 1'b0};
      if (cmaint) begin
         verdict.grant = 1'b1;
      end else if (walk_hit) begin
         verdict.fault     = FLT_PERM;
         verdict.s2        = 1'b1;
         verdict.use_level = 1'b1;
      end else if (align_hit) begin
         verdict.fault = FLT_ALIGN;
         verdict.s2    = stage2;
      end else if (uncpf_hit) begin
         verdict.fault = FLT_UNCPF;
         verdict.pabt  = 1'b1;
         verdict.s2    = stage2;
      end else if (dom_fault) begin
         verdict.fault     = FLT_DOMAIN;
         verdict.pabt      = is_fetch;
         verdict.s2        = stage2;
         verdict.use_level = 1'b1;
      end else if (dom_mgr) begin
         verdict.grant = 1'b1;
      end else if (is_fetch) begin
         if (fetch_abt) begin
            verdict.fault     = FLT_PERM;
            verdict.pabt      = 1'b1;
            verdict.s2        = stage2;
            verdict.use_level = 1'b1;
         end else begin
            verdict.grant = 1'b1;
         end
      end else if (ap_abt || hap_abt) begin
         verdict.fault     = FLT_PERM;
         verdict.s2        = stage2 || !ap_abt;
         verdict.use_level = 1'b1;
      end else begin
         verdict.grant = 1'b1;
      end
   end

endmodule

// File: rtl/xlat_perm_check.sv
module xlat_perm_check
   import apc_pkg::*;
#(
   parameter int  NDOM  = 16,
   parameter int  AW    = 6,
   parameter int  LVL_W = 2,
   localparam int DOM_W = (NDOM > 1) ? $clog2(NDOM) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [1:0]        in_acc,
   input  logic              in_priv,
   input  logic              in_secure,
   input  logic              in_prefetch,
   input  logic              in_cmaint,
   input  logic              in_walk,
   input  logic              in_stage2,
   input  logic [AW-1:0]     in_addr,
   input  logic [AW-1:0]     in_size_mask,
   input  logic [2:0]        ent_ap,
   input  logic [1:0]        ent_hap,
   input  logic              ent_xn,
   input  logic              ent_pxn,
   input  logic [DOM_W-1:0]  ent_dom,
   input  logic              ent_normal,
   input  logic              ent_nc,
   input  logic              ent_ns,
   input  logic              ent_long,
   input  logic [LVL_W-1:0]  ent_level,
   input  logic [2*NDOM-1:0] ctl_dacr,
   input  logic              ctl_align,
   input  logic              ctl_afe,
   input  logic              ctl_wxn,
   input  logic              ctl_uwxn,
   input  logic              ctl_sif,
   input  logic              ctl_walk_chk,
   output logic              out_valid,
   output logic              out_grant,
   output logic [2:0]        out_fault,
   output logic              out_pabt,
   output logic              out_s2,
   output logic [LVL_W-1:0]  out_level
);

   generate
      if (AW < 1 || AW > 12) begin : g_bad_aw
         $error("xlat_perm_check: AW out of range");
      end
      if (LVL_W < 1) begin : g_bad_lvl
         $error("xlat_perm_check: LVL_W must be positive");
      end
   endgenerate

   acc_e     acc;
   logic     is_fetch;
   logic     walk_hit, align_hit, uncpf_hit;
   logic     dom_fault, dom_mgr;
   logic     ap_abt, hap_abt, fetch_abt;
   verdict_t verdict;

   assign acc      = acc_e'(in_acc);
   assign is_fetch = (acc == ACC_FETCH);

   // R3, R4, R5 screening checks
   assign walk_hit  = in_stage2 && in_walk && ctl_walk_chk && !ent_normal;
   assign align_hit = !is_fetch && (|(in_addr & in_size_mask)) &&
                      (!ent_normal || ctl_align);
   assign uncpf_hit = in_prefetch && ent_nc;

   apc_dom_sel #(.NDOM(NDOM), .DOM_W(DOM_W)) u_dom (
      .dacr      (ctl_dacr),
      .dom       (ent_dom),
      .long_fmt  (ent_long),
      .dom_fault (dom_fault),
      .dom_mgr   (dom_mgr)
   );

   apc_ap_eval u_ap (
      .acc       (acc),
      .priv      (in_priv),
      .secure    (in_secure),
      .stage2    (in_stage2),
      .ap        (ent_ap),
      .hap       (ent_hap),
      .xn        (ent_xn),
      .pxn       (ent_pxn),
      .long_fmt  (ent_long),
      .ns        (ent_ns),
      .afe       (ctl_afe),
      .wxn       (ctl_wxn),
      .uwxn      (ctl_uwxn),
      .sif       (ctl_sif),
      .ap_abt    (ap_abt),
      .hap_abt   (hap_abt),
      .fetch_abt (fetch_abt)
   );

   apc_arbiter u_arb (
      .cmaint    (in_cmaint),
      .walk_hit  (walk_hit),
      .align_hit (align_hit),
      .uncpf_hit (uncpf_hit),
      .dom_fault (dom_fault),
      .dom_mgr   (dom_mgr),
      .is_fetch  (is_fetch),
      .fetch_abt (fetch_abt),
      .ap_abt    (ap_abt),
      .hap_abt   (hap_abt),
      .stage2    (in_stage2),
      .verdict   (verdict)
   );

   // R1: registered verdict
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_grant <= 1'b0;
         out_fault <= 3'd0;
         out_pabt  <= 1'b0;
         out_s2    <= 1'b0;
         out_level <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_grant <= verdict.grant;
            out_fault <= verdict.fault;
            out_pabt  <= verdict.pabt;
            out_s2    <= verdict.s2;
            out_level <= verdict.use_level ? ent_level : '0;
         end
      end
   end

   a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   a_r1_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   a_r2_cmaint_grant: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_cmaint) |=> (out_grant && out_fault == 3'd0 && !out_pabt));

   a_r3_walk_fault: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_cmaint && in_stage2 && in_walk && ctl_walk_chk && !ent_normal)
      |=> (out_fault == 3'd3 && !out_pabt && out_s2 && !out_grant));

   a_r4_align_data_side: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_fault == 3'd1) |-> (!out_pabt && !out_grant));

   a_r5_uncached_pabt: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_fault == 3'd4) |-> out_pabt);

   a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(out_grant) && $stable(out_fault)));

endmodule

// File: tb/tb_xlat_perm_check.sv
module tb_xlat_perm_check;

   localparam int NDOM = 4;
   localparam int AW   = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic [1:0] in_acc;
   logic in_priv, in_secure, in_prefetch, in_cmaint, in_walk, in_stage2;
   logic [AW-1:0] in_addr, in_size_mask;
   logic [2:0] ent_ap;
   logic [1:0] ent_hap;
   logic ent_xn, ent_pxn;
   logic [1:0] ent_dom;
   logic ent_normal, ent_nc, ent_ns, ent_long;
   logic [1:0] ent_level;
   logic [2*NDOM-1:0] ctl_dacr;
   logic ctl_align, ctl_afe, ctl_wxn, ctl_uwxn, ctl_sif, ctl_walk_chk;
   logic out_valid, out_grant, out_pabt, out_s2;
   logic [2:0] out_fault;
   logic [1:0] out_level;

   int nvec = 0;
   int nfail = 0;
   logic [31:0] lf = 32'h1234_5679;

   always #10 clk = ~clk;

   xlat_perm_check #(.NDOM(NDOM), .AW(AW), .LVL_W(2)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_acc(in_acc),
      .in_priv(in_priv), .in_secure(in_secure), .in_prefetch(in_prefetch),
      .in_cmaint(in_cmaint), .in_walk(in_walk), .in_stage2(in_stage2),
      .in_addr(in_addr), .in_size_mask(in_size_mask), .ent_ap(ent_ap),
      .ent_hap(ent_hap), .ent_xn(ent_xn), .ent_pxn(ent_pxn), .ent_dom(ent_dom),
      .ent_normal(ent_normal), .ent_nc(ent_nc), .ent_ns(ent_ns),
      .ent_long(ent_long), .ent_level(ent_level), .ctl_dacr(ctl_dacr),
      .ctl_align(ctl_align), .ctl_afe(ctl_afe), .ctl_wxn(ctl_wxn),
      .ctl_uwxn(ctl_uwxn), .ctl_sif(ctl_sif), .ctl_walk_chk(ctl_walk_chk),
      .out_valid(out_valid), .out_grant(out_grant), .out_fault(out_fault),
      .out_pabt(out_pabt), .out_s2(out_s2), .out_level(out_level)
   );

   task automatic step_lf();
      lf = lf ^ (lf << 13);
      lf = lf ^ (lf >> 17);
      lf = lf ^ (lf << 5);
   endtask

   task automatic base();
      in_acc = 2'd0; in_priv = 1; in_secure = 0; in_prefetch = 0; in_cmaint = 0;
      in_walk = 0; in_stage2 = 0; in_addr = '0; in_size_mask = '0;
      ent_ap = 3'd3; ent_hap = 2'd3; ent_xn = 0; ent_pxn = 0; ent_dom = 2'd0;
      ent_normal = 1; ent_nc = 0; ent_ns = 0; ent_long = 0; ent_level = 2'd1;
      ctl_dacr = 8'h55; ctl_align = 0; ctl_afe = 0; ctl_wxn = 0; ctl_uwxn = 0;
      ctl_sif = 0; ctl_walk_chk = 0;
   endtask

   // Reference verdict, written from the requirements
   task automatic model(output logic g, output logic [2:0] f, output logic pa,
                        output logic s2, output logic [1:0] lv, output string tg);
      bit fe, wr, abt, wrt, hab, xnv, fab;
      int a, dc;
      fe = (in_acc == 2'd2);
      wr = (in_acc == 2'd1);
      g = 0; f = 0; pa = 0; s2 = 0; lv = 0; tg = "R2";
      if (in_cmaint) begin g = 1; return; end
      if (in_stage2 && in_walk && ctl_walk_chk && !ent_normal) begin
         f = 3; s2 = 1; lv = ent_level; tg = "R3 R13"; return;
      end
      if (!fe && ((in_addr & in_size_mask) != 0) && (!ent_normal || ctl_align)) begin
         f = 1; s2 = in_stage2; tg = "R4 R13"; return;
      end
      if (in_prefetch && ent_nc) begin
         f = 4; pa = 1; s2 = in_stage2; tg = "R5 R13"; return;
      end
      dc = (int'(ctl_dacr) >> (int'(ent_dom) * 2)) & 3;
      if (!ent_long && (dc == 0 || dc == 2)) begin
         f = 2; pa = fe; s2 = in_stage2; lv = ent_level; tg = "R6"; return;
      end
      if (!ent_long && dc == 3) begin g = 1; tg = "R6"; return; end
      a = ent_long ? (int'(ent_ap) % 4) * 2 : int'(ent_ap);
      if (ent_long || ctl_afe) a = a | 1;
      if (in_stage2) begin
         abt = 0; wrt = 1;
      end else begin
         abt = (a == 0) || (a == 4) || (a == 1 && !in_priv) ||
               (a == 2 && !in_priv && wr) || (a == 5 && (!in_priv || wr)) ||
               (a >= 6 && wr);
         wrt = (a == 3) || (in_priv && (a == 1 || a == 2));
      end
      hab = in_stage2 && (wr ? !ent_hap[1] : !ent_hap[0]);
      xnv = ent_xn || (wrt && ctl_wxn) || (a == 3 && ctl_uwxn && in_priv);
      if (fe) begin
         tg = "R7 R8 R10 R11";
         fab = abt || xnv || (ent_long && ent_pxn && in_priv) ||
               (in_secure && ent_ns && ctl_sif);
         if (fab) begin f = 3; pa = 1; s2 = in_stage2; lv = ent_level; end
         else g = 1;
      end else begin
         tg = "R7 R8 R9 R12";
         if (abt || hab) begin f = 3; s2 = in_stage2 || !abt; lv = ent_level; end
         else g = 1;
      end
   endtask

   task automatic apply();
      logic eg, ep, es;
      logic [2:0] ef;
      logic [1:0] el;
      string tg;
      model(eg, ef, ep, es, el, tg);
      @(negedge clk);
      in_valid = 1;
      @(negedge clk);
      in_valid = 0;
      nvec++;
      if (out_valid !== 1'b1 || out_grant !== eg || out_fault !== ef ||
          out_pabt !== ep || out_s2 !== es || out_level !== el) begin
         nfail++;
         $display("FAIL %s R1: got v=%0d g=%0d f=%0d pa=%0d s2=%0d lv=%0d, expected v=1 g=%0d f=%0d pa=%0d s2=%0d lv=%0d",
                  tg, out_valid, out_grant, out_fault, out_pabt, out_s2, out_level,
                  eg, ef, ep, es, el);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nfail++;
      $display("FAIL R1 watchdog: got no completion, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end

   initial begin
      base();
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state
      nvec++;
      if (out_valid !== 0 || out_grant !== 0 || out_fault !== 0 || out_pabt !== 0 ||
          out_s2 !== 0 || out_level !== 0) begin
         nfail++;
         $display("FAIL R1 reset: got v=%0d g=%0d f=%0d, expected all zero",
                  out_valid, out_grant, out_fault);
      end
      rst_n = 1;
      @(negedge clk);

      // Permission sweep: R7 R8 R9 R10 R11 R12
      for (int acc = 0; acc < 3; acc++)
      for (int ap = 0; ap < 8; ap++)
      for (int pv = 0; pv < 2; pv++)
      for (int lg = 0; lg < 2; lg++)
      for (int af = 0; af < 2; af++)
      for (int wx = 0; wx < 4; wx++)
      for (int s2 = 0; s2 < 2; s2++)
      for (int hp = 0; hp < 4; hp++) begin
         base();
         step_lf();
         in_acc = 2'(acc); ent_ap = 3'(ap); in_priv = pv[0]; ent_long = lg[0];
         ctl_afe = af[0]; ctl_wxn = wx[0]; ctl_uwxn = wx[1]; in_stage2 = s2[0];
         ent_hap = 2'(hp); ent_dom = lf[1:0]; ent_level = lf[3:2];
         ent_xn = lf[4] & lf[5]; ent_pxn = lf[6]; in_secure = lf[7];
         ent_ns = lf[8]; ctl_sif = lf[9];
         apply();
      end

      // Domain sweep: R6
      for (int acc = 0; acc < 3; acc++)
      for (int d = 0; d < 4; d++)
      for (int fv = 0; fv < 4; fv++)
      for (int lg = 0; lg < 2; lg++)
      for (int ak = 0; ak < 2; ak++) begin
         base();
         step_lf();
         in_acc = 2'(acc); ent_dom = 2'(d); ent_long = lg[0];
         ent_ap = ak[0] ? 3'd3 : 3'd0;
         ctl_dacr = lf[7:0];
         ctl_dacr[2*d +: 2] = 2'(fv);
         apply();
      end

      // Directed: R13 walk check beats alignment and uncached prefetch
      base();
      in_stage2 = 1; in_walk = 1; ctl_walk_chk = 1; ent_normal = 0;
      in_addr = 3'b001; in_size_mask = 3'b001; in_prefetch = 1; ent_nc = 1;
      ent_level = 2'd2;
      apply();
      // R4: device memory, address bits outside the mask
      base();
      ent_normal = 0; in_addr = 3'b100; in_size_mask = 3'b011;
      apply();
      // R4: ctl_align on normal memory
      base();
      ctl_align = 1; in_addr = 3'b010; in_size_mask = 3'b011; in_acc = 2'd1;
      apply();
      // R2: cache maintenance with every check firing
      base();
      in_cmaint = 1; in_stage2 = 1; in_walk = 1; ctl_walk_chk = 1; ent_normal = 0;
      in_addr = 3'b111; in_size_mask = 3'b111; ctl_dacr = 8'h00; ent_ap = 3'd0;
      apply();

      // R1: outputs hold while idle
      base();
      ent_ap = 3'd0; in_acc = 2'd1;
      apply();
      repeat (3) @(negedge clk);
      nvec++;
      if (out_valid !== 0 || out_fault !== 3'd3 || out_grant !== 0) begin
         nfail++;
         $display("FAIL R1 hold: got v=%0d f=%0d g=%0d, expected v=0 f=3 g=0",
                  out_valid, out_fault, out_grant);
      end

      // Mixed priority run: R13
      for (int k = 0; k < 3000; k++) begin
         step_lf();
         in_acc = lf[1:0]; in_priv = lf[2]; in_secure = lf[3]; in_prefetch = lf[4];
         in_cmaint = lf[5] & lf[6] & lf[7]; in_walk = lf[8]; in_stage2 = lf[9];
         in_addr = lf[12:10]; in_size_mask = lf[15:13]; ent_ap = lf[18:16];
         ent_hap = lf[20:19]; ent_xn = lf[21]; ent_pxn = lf[22]; ent_dom = lf[24:23];
         ent_normal = lf[25]; ent_nc = lf[26]; ent_ns = lf[27]; ent_long = lf[28];
         ent_level = lf[30:29];
         step_lf();
         ctl_dacr = lf[7:0]; ctl_align = lf[8]; ctl_afe = lf[9]; ctl_wxn = lf[10];
         ctl_uwxn = lf[11]; ctl_sif = lf[12]; ctl_walk_chk = lf[13];
         apply();
      end

      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end

endmodule